// File: doc/BRIEF.md
# Register Condition and Compare Unit

This unit serves an integer datapath that keeps no flags register. A branch or conditional-move condition is judged straight from the value of one source register: its zero state, its sign bit and its least significant bit. The same unit also forms boolean compare results, which are the value 0 or 1 zero-extended to the full data width.

The unit is purely combinational. In each cycle it takes a test operand, a second operand, the old destination value and an operation select, and it returns three things: whether the condition holds, a data result and a write-enable. The second operand is either a full register value or a short literal. When it is a literal it is zero-extended before use. Instruction decode, the register file, forwarding and pipeline registers sit outside the unit.

The unit has no storage, so there is no valid/ready handshake. A result is tied to the inputs present in the same cycle, and the unit never stalls its caller.

Top module: `rcc_unit`

## Requirements
- R1: When `op_kind` is 0 (test), `cond_true` reports the condition chosen by `sel`: 0 value is zero, 1 value is non-zero, 2 signed less than zero, 3 signed at least zero, 4 signed greater than zero, 5 signed at most zero, 6 bit 0 clear (even), 7 bit 0 set (odd).
- R2: Every condition looks at all 64 bits of `test_opd`. For example, a value whose only set bit is bit 40 counts as non-zero.
- R3: When `op_kind` is 1 (move) and the condition holds, `result` equals the second operand and `wr_en` is 1.
- R4: When `op_kind` is 1 and the condition fails, `wr_en` is 0 and `result` equals `old_dest`.
- R5: When `op_kind` is 2 (compare), `sel` picks the comparison of `test_opd` against the second operand: 0 equal, 1 signed less, 2 signed less-or-equal, 3 unsigned less, 4 unsigned less-or-equal. All 64 bits take part.
- R6: A compare with `sel` from 0 to 4 gives `result` equal to exactly 0 or 1, sets `wr_en` to 1, and makes `cond_true` equal to `result[0]`.
- R7: When `use_lit` is 1, the second operand is `lit_val` zero-extended to 64 bits, and `src_reg` has no effect. When `use_lit` is 0, the second operand is `src_reg`.
- R8: A compare with `sel` from 5 to 7, or any cycle with `op_kind` equal to 3, gives `result` 0, `wr_en` 0 and `cond_true` 0.
- R9: In test mode (`op_kind` 0), `result` is 0 and `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_opd | input | 64 | Value tested by the condition, and left operand of a compare |
| src_reg | input | 64 | Register second operand |
| lit_val | input | 8 | Literal second operand |
| use_lit | input | 1 | 1 selects the zero-extended literal as second operand |
| old_dest | input | 64 | Current destination value, returned when a move is suppressed |
| op_kind | input | 2 | 0 test, 1 move, 2 compare, 3 none |
| sel | input | 3 | Condition code (test and move) or compare code |
| cond_true | output | 1 | Condition or compare outcome |
| result | output | 64 | Move value or compare boolean |
| wr_en | output | 1 | Destination write-enable |

## Verification
Condition evaluation and operand selection meet in the same cycle during a conditional move. The result of that move depends both on the condition judged from `test_opd` and on whether the literal or the register feeds the second operand. Random vectors mix moves with `use_lit` set and `src_reg` filled with noise, so a wrong operand or a wrong condition shows up at once. Every cycle's `result`, `wr_en` and `cond_true` are compared against bench functions. Directed cases place the only set bit above bit 31, and pit the most negative value against small positives, to separate signed from unsigned and to catch narrow zero tests.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  typedef enum logic [1:0] {
    OPK_TEST = 2'd0,
    OPK_MOVE = 2'd1,
    OPK_CMP  = 2'd2,
    OPK_NONE = 2'd3
  } opk_e;

  typedef enum logic [2:0] {
    CND_ZERO   = 3'd0,
    CND_NZERO  = 3'd1,
    CND_NEG    = 3'd2,
    CND_NONNEG = 3'd3,
    CND_POS    = 3'd4,
    CND_NONPOS = 3'd5,
    CND_EVEN   = 3'd6,
    CND_ODD    = 3'd7
  } cnd_e;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_SLT = 3'd1,
    CMP_SLE = 3'd2,
    CMP_ULT = 3'd3,
    CMP_ULE = 3'd4
  } cmp_e;

  localparam int unsigned NUM_CND = 8;
endpackage

// File: rtl/rcc_operand_sel.sv
module rcc_operand_sel #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LIT_W  = 8
) (
  input  logic [DATA_W-1:0] reg_val,
  input  logic [LIT_W-1:0]  lit_val,
  input  logic              use_lit,
  output logic [DATA_W-1:0] opnd
);
  localparam int unsigned PAD_W = DATA_W - LIT_W;

  always_comb begin
    if (use_lit) opnd = {{PAD_W{1'b0}}, lit_val};
    else         opnd = reg_val;
    if (use_lit) begin
      AST_LIT_ZEXT: assert (opnd[DATA_W-1:LIT_W] == '0 && opnd[LIT_W-1:0] == lit_val); // R7
    end
  end
endmodule

// File: rtl/rcc_cond_eval.sv
module rcc_cond_eval
  import rcc_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] value,
  input  logic [2:0]        sel,
  output logic              hit
);
  logic              is_zero;
  logic              sign_b;
  logic [NUM_CND-1:0] flags;

  always_comb begin
    is_zero = (value == '0);
    sign_b  = value[DATA_W-1];
    flags[CND_ZERO]   = is_zero;
    flags[CND_NZERO]  = !is_zero;
    flags[CND_NEG]    = sign_b;
    flags[CND_NONNEG] = !sign_b;
    flags[CND_POS]    = !sign_b && !is_zero;
    flags[CND_NONPOS] = sign_b || is_zero;
    flags[CND_EVEN]   = !value[0];
    flags[CND_ODD]    = value[0];
    hit = flags[sel];
    AST_COND_PAIRS: assert (flags[0] != flags[1] && flags[2] != flags[3] &&
                            flags[4] != flags[5] && flags[6] != flags[7]); // R1
    AST_SIGN_SPLIT: assert ($onehot({flags[CND_NEG], flags[CND_ZERO], flags[CND_POS]})); // R2
  end
endmodule

// File: rtl/rcc_compare.sv
module rcc_compare
  import rcc_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [2:0]        sel,
  output logic              bit_out,
  output logic              sel_ok
);
  logic eq_b, ult_b, slt_b;

  always_comb begin
    eq_b  = (a == b);
    ult_b = (a < b);
    slt_b = ($signed(a) < $signed(b));
    sel_ok = 1'b1;
    unique case (sel)
      CMP_EQ:  bit_out = eq_b;
      CMP_SLT: bit_out = slt_b;
      CMP_SLE: bit_out = slt_b || eq_b;
      CMP_ULT: bit_out = ult_b;
      CMP_ULE: bit_out = ult_b || eq_b;
      default: begin
        bit_out = 1'b0;
        sel_ok  = 1'b0;
      end
    endcase
    AST_ORDER_EXCL: assert (!(eq_b && (ult_b || slt_b))); // R5
    AST_SIGN_FLIP: assert ((a[DATA_W-1] == b[DATA_W-1]) ? (ult_b == slt_b) : (ult_b != slt_b)); // R5
  end
endmodule

// File: rtl/rcc_unit.sv
module rcc_unit
  import rcc_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LIT_W  = 8
) (
  input  logic [DATA_W-1:0] test_opd,
  input  logic [DATA_W-1:0] src_reg,
  input  logic [LIT_W-1:0]  lit_val,
  input  logic              use_lit,
  input  logic [DATA_W-1:0] old_dest,
  input  logic [1:0]        op_kind,
  input  logic [2:0]        sel,
  output logic              cond_true,
  output logic [DATA_W-1:0] result,
  output logic              wr_en
);
  logic [DATA_W-1:0] opnd_b;
  logic              cnd_hit;
  logic              cmp_bit;
  logic              cmp_ok;

  rcc_operand_sel #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_opsel (
    .reg_val(src_reg), .lit_val(lit_val), .use_lit(use_lit), .opnd(opnd_b)
  );

  rcc_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .value(test_opd), .sel(sel), .hit(cnd_hit)
  );

  rcc_compare #(.DATA_W(DATA_W)) u_cmp (
    .a(test_opd), .b(opnd_b), .sel(sel), .bit_out(cmp_bit), .sel_ok(cmp_ok)
  );

  always_comb begin
    cond_true = 1'b0;
    result    = '0;
    wr_en     = 1'b0;
    case (op_kind)
      OPK_TEST: cond_true = cnd_hit;
      OPK_MOVE: begin
        cond_true = cnd_hit;
        wr_en     = cnd_hit;
        result    = cnd_hit ? opnd_b : old_dest;
      end
      OPK_CMP: begin
        cond_true = cmp_bit;
        wr_en     = cmp_ok;
        result    = {{(DATA_W-1){1'b0}}, cmp_bit};
      end
      default: ;
    endcase
    if (op_kind == OPK_MOVE && !wr_en) begin
      AST_MOVE_KEEP: assert (result == old_dest); // R4
    end
    if (op_kind == OPK_MOVE && wr_en) begin
      AST_MOVE_TAKE: assert (result == opnd_b && cond_true); // R3
    end
    if (op_kind == OPK_CMP) begin
      AST_CMP_BOOL: assert (result[DATA_W-1:1] == '0 && result[0] == cond_true); // R6
    end
    if (op_kind == OPK_TEST || op_kind == OPK_NONE) begin
      AST_NO_WRITE: assert (!wr_en && result == '0); // R9
    end
  end
endmodule

// File: tb/rcc_unit_bench.sv
module rcc_unit_bench;
  logic        clk = 1'b0;
  logic [63:0] test_opd, src_reg, old_dest;
  logic [7:0]  lit_val;
  logic        use_lit;
  logic [1:0]  op_kind;
  logic [2:0]  sel;
  logic        cond_true, wr_en;
  logic [63:0] result;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  rcc_unit u_rcc_unit (
    .test_opd(test_opd), .src_reg(src_reg), .lit_val(lit_val), .use_lit(use_lit),
    .old_dest(old_dest), .op_kind(op_kind), .sel(sel),
    .cond_true(cond_true), .result(result), .wr_en(wr_en)
  );

  function automatic bit ref_cond(input logic [63:0] v, input logic [2:0] s);
    case (s)
      3'd0: return v == 64'd0;
      3'd1: return v != 64'd0;
      3'd2: return v[63];
      3'd3: return !v[63];
      3'd4: return !v[63] && v != 64'd0;
      3'd5: return v[63] || v == 64'd0;
      3'd6: return !v[0];
      default: return v[0];
    endcase
  endfunction

  function automatic bit ref_cmp(input logic [63:0] a, input logic [63:0] b, input logic [2:0] s);
    case (s)
      3'd0: return a == b;
      3'd1: return $signed(a) < $signed(b);
      3'd2: return $signed(a) <= $signed(b);
      3'd3: return a < b;
      3'd4: return a <= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input logic [63:0] t, input logic [63:0] r, input logic [7:0] l,
                       input logic ul, input logic [63:0] od, input logic [1:0] k,
                       input logic [2:0] s, input string tag);
    logic [63:0] b, exp_res;
    bit exp_c, exp_w;
    @(negedge clk);
    test_opd = t; src_reg = r; lit_val = l; use_lit = ul; old_dest = od; op_kind = k; sel = s;
    #1;
    b = ul ? {56'd0, l} : r;
    exp_c = 0; exp_w = 0; exp_res = 64'd0;
    case (k)
      2'd0: exp_c = ref_cond(t, s);
      2'd1: begin
        exp_c = ref_cond(t, s); exp_w = exp_c; exp_res = exp_c ? b : od;
      end
      2'd2: begin
        exp_c = ref_cmp(t, b, s); exp_w = (s <= 3'd4); exp_res = {63'd0, exp_c};
      end
      default: ;
    endcase
    checks++;
    if (cond_true !== exp_c || wr_en !== exp_w || result !== exp_res) begin
      fails++;
      $display("FAIL %s: got c=%0b w=%0b r=%h exp c=%0b w=%0b r=%h",
               tag, cond_true, wr_en, result, exp_c, exp_w, exp_res);
    end
  endtask

  initial begin
    test_opd = '0; src_reg = '0; lit_val = '0; use_lit = 0; old_dest = '0; op_kind = 0; sel = 0;
    apply(64'd0, 64'd0, 8'd0, 0, 64'd0, 2'd0, 3'd0, "R9 idle zero");
    for (int s = 0; s < 8; s++) begin
      apply(64'd0, 64'd0, 8'd0, 0, 64'd0, 2'd0, 3'(s), "R1 zero value");
      apply(64'h8000_0000_0000_0000, 64'd0, 8'd0, 0, 64'd0, 2'd0, 3'(s), "R1 most negative");
      apply(64'd3, 64'd0, 8'd0, 0, 64'd0, 2'd0, 3'(s), "R1 small odd");
      apply(64'hFFFF_FFFF_FFFF_FFFE, 64'd0, 8'd0, 0, 64'd0, 2'd0, 3'(s), "R1 minus two");
      apply(64'h0000_0100_0000_0000, 64'd0, 8'd0, 0, 64'd0, 2'd0, 3'(s), "R2 high bit only");
    end
    apply(64'h0000_0100_0000_0000, 64'h1234, 8'd0, 0, 64'hDEAD, 2'd1, 3'd1, "R3 move taken");
    apply(64'h0000_0100_0000_0000, 64'h1234, 8'd0, 0, 64'hDEAD, 2'd1, 3'd0, "R4 move suppressed");
    apply(64'd5, 64'hFFFF_0000_FFFF_0000, 8'hA5, 1, 64'hBEEF, 2'd1, 3'd7, "R7 move literal");
    apply(64'd5, 64'hFFFF_0000_FFFF_0000, 8'hA5, 1, 64'hBEEF, 2'd1, 3'd6, "R4 move odd fail");
    apply(64'h8000_0000_0000_0000, 64'd1, 8'd0, 0, 64'd0, 2'd2, 3'd1, "R5 slt neg");
    apply(64'h8000_0000_0000_0000, 64'd1, 8'd0, 0, 64'd0, 2'd2, 3'd3, "R5 ult neg");
    apply(64'd7, 64'd7, 8'd0, 0, 64'd0, 2'd2, 3'd2, "R5 sle equal");
    apply(64'd7, 64'd7, 8'd0, 0, 64'd0, 2'd2, 3'd3, "R5 ult equal");
    apply(64'd7, 64'd7, 8'd0, 0, 64'd0, 2'd2, 3'd4, "R6 ule equal");
    apply(64'h1_0000_00FF, 64'd0, 8'hFF, 1, 64'd0, 2'd2, 3'd0, "R7 literal eq full width");
    apply(64'hFF, 64'h5555, 8'hFF, 1, 64'd0, 2'd2, 3'd0, "R7 literal eq");
    for (int s = 5; s < 8; s++)
      apply(64'd1, 64'd2, 8'd0, 0, 64'h77, 2'd2, 3'(s), "R8 reserved compare");
    apply(64'd1, 64'd2, 8'd3, 1, 64'h77, 2'd3, 3'd1, "R8 none kind");
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] t, r, od;
      t  = {$urandom, $urandom};
      r  = {$urandom, $urandom};
      od = {$urandom, $urandom};
      if (i % 5 == 0) t = r;
      if (i % 7 == 0) t = {56'd0, t[7:0]};
      apply(t, r, 8'($urandom), 1'($urandom), od, 2'($urandom), 3'($urandom),
            "R3 R4 R5 R6 R7 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    process::self().srandom(32'd9157);
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule